// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block holds the per-channel transfer registers of a multi-channel DMA controller. Each channel has a 16-bit base address, a 16-bit base count, a current address and a counter of how much has been transferred so far. Software reaches the registers through a byte-wide I/O port. Every 16-bit value moves one byte at a time, and a single byte-pointer flip-flop, shared by all channels, chooses the low or the high byte.

When the high byte of either base register is written, the channel restarts. The current address is loaded from the base address and the progress counter is cleared. The transfer engine advances a channel through a step-increment port. Read-back is not a stored value: it is derived from the base and the progress. For the address register the progress is added or subtracted, depending on the channel's direction input. For the count register the progress is subtracted from the base count.

The `SHIFT` parameter selects byte mode (0) or word mode (1). In word mode the port decode ignores the lowest address bit, the current address is the base address doubled, and read-back bytes are taken one bit higher.

Top module: `dma_chan_regs`

## Requirements
- R1: The register index is (port_addr >> SHIFT) & 0xF. The channel number is index >> 1. Index bit 0 selects the address register when 0 and the count register when 1. An access whose index is 2*NUM_CH or more changes no register, does not move the byte pointer and produces no read response.
- R2: The byte pointer is 0 after reset. Every accepted read or write inverts it. A value of 0 addresses bits 7:0 and a value of 1 addresses bits 15:8.
- R3: `ff_clear` forces the byte pointer to 0 at the next edge. This takes priority over an accepted access in the same cycle.
- R4: A low-byte write replaces only bits 7:0 of the selected base register. A high-byte write replaces only bits 15:8.
- R5: A high-byte write to either register of a channel loads that channel's current address with its new base address shifted left by SHIFT, and clears its progress to zero. A low-byte write does neither.
- R6: A count read evaluates (base count << SHIFT) minus progress, modulo 2^(16+SHIFT).
- R7: An address read evaluates current address plus progress. When the channel's `dir_down` bit is 1 it evaluates current address minus progress instead.
- R8: A read returns bits [SHIFT+8*p+7 : SHIFT+8*p] of the evaluated value, where p is the byte pointer before the access. The byte appears on `rd_data` with `rd_valid` high for one cycle, on the edge after the read strobe.
- R9: `inc_valid` adds `inc_step` to the progress of channel `inc_chan`. The add is dropped when the same cycle carries a high-byte write to that channel; other channels still advance.
- R10: After reset every base register, current address and progress counter is zero, so every read returns 0x00.
- R11: When `wr_en` and `rd_en` are both high, only the write is performed. The pointer moves once and no read response is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_addr | input | PORT_AW | I/O port address of the access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write byte |
| ff_clear | input | 1 | Clear the shared byte pointer |
| dir_down | input | NUM_CH | Per-channel address-decrement selection |
| inc_valid | input | 1 | Transfer-engine progress step valid |
| inc_chan | input | $clog2(NUM_CH) | Channel being advanced |
| inc_step | input | 16+SHIFT | Amount to add to progress |
| rd_data | output | 8 | Read-back byte (registered) |
| rd_valid | output | 1 | Read-back byte valid, one-cycle pulse |

## Verification
The hardest case to reach from the ports is a progress step that lands in the same cycle as the high-byte write that restarts the channel. The stimulus first writes the low address byte. It then asserts the increment strobe for that channel, and for a second channel, during the cycle of the high-byte write. Later reads show the restarted channel at zero progress while the other channel has advanced. Pointer priority is reached in a similar way: a clear is driven in the same cycle as an access made while the pointer is 0. The next read must then return a low byte.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int BYTE_W = 8;
  localparam int BASE_W = 16;

  typedef enum logic {
    SEL_ADDR  = 1'b0,
    SEL_COUNT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/chan_port_decode.sv
module chan_port_decode
  import dma_chan_pkg::*;
#(
  parameter int PORT_AW = 8,
  parameter int SHIFT   = 0,
  parameter int NUM_CH  = 4,
  localparam int CHW    = $clog2(NUM_CH)
) (
  input  logic [PORT_AW-1:0] addr,
  output logic               hit,
  output logic [CHW-1:0]     chan,
  output reg_sel_e           sel
);
  logic [PORT_AW-1:0] addr_sh;
  logic [3:0]         idx;
  logic               unused_hi;

  always_comb begin
    addr_sh   = addr >> SHIFT;
    idx       = addr_sh[3:0];
    unused_hi = ^addr_sh[PORT_AW-1:4];
    hit       = {1'b0, idx} < 5'(2 * NUM_CH);
    chan      = idx[CHW:1];
    sel       = idx[0] ? SEL_COUNT : SEL_ADDR;
  end
endmodule

// File: rtl/chan_byte_ptr.sv
module chan_byte_ptr (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic ptr_q
);
  always_ff @(posedge clk) begin
    if (rst)        ptr_q <= 1'b0;
    else if (clear) ptr_q <= 1'b0;
    else if (step)  ptr_q <= ~ptr_q;
  end

  a_r3_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clear |=> !ptr_q);
  a_r2_toggle: assert property (@(posedge clk) disable iff (rst)
    (step && !clear) |=> (ptr_q != $past(ptr_q)));
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!step && !clear) |=> $stable(ptr_q));
endmodule

// File: rtl/chan_reg_slice.sv
module chan_reg_slice
  import dma_chan_pkg::*;
#(
  parameter int SHIFT = 0,
  localparam int VW   = BASE_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  reg_sel_e          sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              inc_en,
  input  logic [VW-1:0]     inc_step,
  output logic [BASE_W-1:0] base_addr,
  output logic [BASE_W-1:0] base_cnt,
  output logic [VW-1:0]     cur_addr,
  output logic [VW-1:0]     xfer
);
  logic [BASE_W-1:0] ba_n, bc_n;

  always_comb begin
    ba_n = base_addr;
    bc_n = base_cnt;
    if (wr_lo) begin
      if (sel == SEL_ADDR) ba_n[7:0] = wdata;
      else                 bc_n[7:0] = wdata;
    end
    if (wr_hi) begin
      if (sel == SEL_ADDR) ba_n[15:8] = wdata;
      else                 bc_n[15:8] = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      xfer      <= '0;
    end else begin
      base_addr <= ba_n;
      base_cnt  <= bc_n;
      if (wr_hi) begin
        cur_addr <= VW'(ba_n) << SHIFT;
        xfer     <= '0;
      end else if (inc_en) begin
        xfer <= xfer + inc_step;
      end
    end
  end

  a_r5_reload: assert property (@(posedge clk) disable iff (rst)
    wr_hi |=> (xfer == '0) && (cur_addr == (VW'(base_addr) << SHIFT)));
  a_r5_lo_no_reload: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !inc_en) |=> $stable(cur_addr) && $stable(xfer));
  a_r4_lo_keeps_hi: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && sel == SEL_ADDR) |=> (base_addr[15:8] == $past(base_addr[15:8])));
  a_r4_hi_keeps_lo: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && sel == SEL_COUNT) |=> (base_cnt[7:0] == $past(base_cnt[7:0])));
  a_r9_inc_adds: assert property (@(posedge clk) disable iff (rst)
    (inc_en && !wr_hi) |=> (xfer == $past(xfer) + $past(inc_step)));
  a_r9_inc_dropped: assert property (@(posedge clk) disable iff (rst)
    (inc_en && wr_hi) |=> (xfer == '0));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int SHIFT   = 0,
  parameter int PORT_AW = 8,
  localparam int CHW    = $clog2(NUM_CH),
  localparam int VW     = BASE_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_AW-1:0] port_addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ff_clear,
  input  logic [NUM_CH-1:0] dir_down,
  input  logic              inc_valid,
  input  logic [CHW-1:0]    inc_chan,
  input  logic [VW-1:0]     inc_step,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid
);
  logic           hit;
  logic [CHW-1:0] chan;
  reg_sel_e       sel;
  logic           ptr_q;
  logic           wr_acc, rd_acc, any_acc;

  logic [BASE_W-1:0] base_a [NUM_CH];
  logic [BASE_W-1:0] base_c [NUM_CH];
  logic [VW-1:0]     cur_a  [NUM_CH];
  logic [VW-1:0]     prog   [NUM_CH];

  chan_port_decode #(.PORT_AW(PORT_AW), .SHIFT(SHIFT), .NUM_CH(NUM_CH)) u_dec (
    .addr (port_addr),
    .hit  (hit),
    .chan (chan),
    .sel  (sel)
  );

  always_comb begin
    wr_acc  = wr_en && hit;
    rd_acc  = rd_en && !wr_en && hit;
    any_acc = wr_acc || rd_acc;
  end

  chan_byte_ptr u_ptr (
    .clk   (clk),
    .rst   (rst),
    .clear (ff_clear),
    .step  (any_acc),
    .ptr_q (ptr_q)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic mine;
    assign mine = wr_acc && (chan == CHW'(g));

    chan_reg_slice #(.SHIFT(SHIFT)) u_slice (
      .clk       (clk),
      .rst       (rst),
      .wr_lo     (mine && !ptr_q),
      .wr_hi     (mine && ptr_q),
      .sel       (sel),
      .wdata     (wr_data),
      .inc_en    (inc_valid && (inc_chan == CHW'(g))),
      .inc_step  (inc_step),
      .base_addr (base_a[g]),
      .base_cnt  (base_c[g]),
      .cur_addr  (cur_a[g]),
      .xfer      (prog[g])
    );
  end

  logic [VW-1:0]     a_val, c_val, rb_val, rb_sh;
  logic [BYTE_W-1:0] rb_byte;

  always_comb begin
    a_val   = dir_down[chan] ? (cur_a[chan] - prog[chan])
                             : (cur_a[chan] + prog[chan]);
    c_val   = (VW'(base_c[chan]) << SHIFT) - prog[chan];
    rb_val  = (sel == SEL_COUNT) ? c_val : a_val;
    rb_sh   = rb_val >> SHIFT;
    rb_byte = ptr_q ? rb_sh[15:8] : rb_sh[7:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_acc;
      if (rd_acc) rd_data <= rb_byte;
    end
  end

  a_r8_rd_pulse: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && hit) |=> rd_valid);
  a_r11_no_resp: assert property (@(posedge clk) disable iff (rst)
    (wr_en || !rd_en) |=> !rd_valid);
  a_r1_outside_ignored: assert property (@(posedge clk) disable iff (rst)
    ((rd_en || wr_en) && !hit && !ff_clear) |=> $stable(ptr_q) && !rd_valid);
  a_r8_hold_data: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |=> (rd_valid || $stable(rd_data)));
endmodule

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int total = 0;
  int bad   = 0;

  // byte-mode instance
  logic [7:0]  port_addr = '0;
  logic        wr_en = 0, rd_en = 0, ff_clear = 0, inc_valid = 0;
  logic [7:0]  wr_data = '0;
  logic [3:0]  dir_down = '0;
  logic [1:0]  inc_chan = '0;
  logic [15:0] inc_step = '0;
  logic [7:0]  rd_data;
  logic        rd_valid;

  dma_chan_regs #(.NUM_CH(4), .SHIFT(0), .PORT_AW(8)) u_dut (
    .clk(clk), .rst(rst), .port_addr(port_addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .ff_clear(ff_clear), .dir_down(dir_down),
    .inc_valid(inc_valid), .inc_chan(inc_chan), .inc_step(inc_step),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // word-mode instance
  logic [7:0]  w_addr = '0;
  logic        w_wr = 0, w_rd = 0, w_inc = 0;
  logic [7:0]  w_wdata = '0;
  logic [1:0]  w_inc_chan = '0;
  logic [16:0] w_step = '0;
  logic [7:0]  w_rdata;
  logic        w_rvalid;

  dma_chan_regs #(.NUM_CH(4), .SHIFT(1), .PORT_AW(8)) u_dut_w (
    .clk(clk), .rst(rst), .port_addr(w_addr), .wr_en(w_wr), .rd_en(w_rd),
    .wr_data(w_wdata), .ff_clear(1'b0), .dir_down(4'b0000),
    .inc_valid(w_inc), .inc_chan(w_inc_chan), .inc_step(w_step),
    .rd_data(w_rdata), .rd_valid(w_rvalid)
  );

  item_t q[$];
  item_t wq[$];

  // bench model of the byte-mode instance
  logic [15:0] m_ba [4];
  logic [15:0] m_bc [4];
  logic [15:0] m_cur[4];
  logic [15:0] m_xf [4];
  logic        m_ff;

  function automatic logic [7:0] model_byte(int ch, bit cnt);
    logic [15:0] v;
    if (cnt)              v = m_bc[ch] - m_xf[ch];
    else if (dir_down[ch]) v = m_cur[ch] - m_xf[ch];
    else                  v = m_cur[ch] + m_xf[ch];
    return m_ff ? v[15:8] : v[7:0];
  endfunction

  task automatic cyc(input bit rd, input bit wr, input int idx, input logic [7:0] d,
                     input bit clr, input bit inc_on, input int inc_ch, input int step,
                     input string tag);
    bit    hit;
    int    ch;
    bit    cnt;
    bit    reload;
    item_t it;
    port_addr = 8'(idx);
    rd_en = rd; wr_en = wr; wr_data = d; ff_clear = clr;
    inc_valid = inc_on; inc_chan = 2'(inc_ch); inc_step = 16'(step);
    hit = (idx % 16) < 8;
    ch  = (idx % 16) / 2 % 4;
    cnt = idx[0];
    reload = 0;
    if (hit && rd && !wr) begin
      it.exp = model_byte(ch, cnt);
      it.tag = tag;
      q.push_back(it);
    end
    if (hit && wr) begin
      if (!m_ff) begin
        if (cnt) m_bc[ch][7:0] = d; else m_ba[ch][7:0] = d;
      end else begin
        if (cnt) m_bc[ch][15:8] = d; else m_ba[ch][15:8] = d;
        m_cur[ch] = m_ba[ch];
        m_xf[ch]  = '0;
        reload = 1;
      end
    end
    if (inc_on && !(reload && inc_ch == ch)) m_xf[inc_ch] = m_xf[inc_ch] + 16'(step);
    if (clr) m_ff = 0;
    else if (hit && (rd || wr)) m_ff = !m_ff;
    @(negedge clk);
    rd_en = 0; wr_en = 0; ff_clear = 0; inc_valid = 0;
  endtask

  task automatic wr(input int idx, input logic [7:0] d);
    cyc(0, 1, idx, d, 0, 0, 0, 0, "");
  endtask
  task automatic rd(input int idx, input string tag);
    cyc(1, 0, idx, 8'h00, 0, 0, 0, 0, tag);
  endtask
  task automatic inc(input int ch, input int step);
    cyc(0, 0, 0, 8'h00, 0, 1, ch, step, "");
  endtask

  task automatic wcyc(input bit rdx, input bit wrx, input int port, input logic [7:0] d,
                      input bit incx, input int step, input logic [7:0] exp, input string tag);
    item_t it;
    w_addr = 8'(port); w_rd = rdx; w_wr = wrx; w_wdata = d;
    w_inc = incx; w_inc_chan = 2'd1; w_step = 17'(step);
    if (rdx) begin it.exp = exp; it.tag = tag; wq.push_back(it); end
    @(negedge clk);
    w_rd = 0; w_wr = 0; w_inc = 0;
  endtask

  // monitors
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      total++;
      if (q.size() == 0) begin
        bad++;
        $display("FAIL R1/R11 unexpected response: actual=%02h expected=none", rd_data);
      end else begin
        item_t it;
        it = q.pop_front();
        if (rd_data !== it.exp) begin
          bad++;
          $display("FAIL %s byte mode: actual=%02h expected=%02h", it.tag, rd_data, it.exp);
        end
      end
    end
    if (!rst && w_rvalid) begin
      total++;
      if (wq.size() == 0) begin
        bad++;
        $display("FAIL R8 word mode unexpected response: actual=%02h expected=none", w_rdata);
      end else begin
        item_t it;
        it = wq.pop_front();
        if (w_rdata !== it.exp) begin
          bad++;
          $display("FAIL %s word mode: actual=%02h expected=%02h", it.tag, w_rdata, it.exp);
        end
      end
    end
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_ba[i] = '0; m_bc[i] = '0; m_cur[i] = '0; m_xf[i] = '0;
    end
    m_ff = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R10 reset state, R2 pointer starts low
    rd(0, "R10"); rd(0, "R10");
    rd(7, "R10"); rd(7, "R10");

    // R4/R8 basic byte order on channel 0 address and count
    wr(0, 8'h34); wr(0, 8'h12);
    wr(1, 8'hFF); wr(1, 8'h00);
    rd(0, "R4"); rd(0, "R4");
    rd(1, "R8"); rd(1, "R8");

    // R5 low-byte write alone does not reload; R3 clear realigns
    wr(2, 8'hAB); wr(2, 8'hCD);
    wr(2, 8'h11);
    cyc(0, 0, 0, 8'h00, 1, 0, 0, 0, "");
    rd(2, "R5"); rd(2, "R5");
    wr(2, 8'h11); wr(2, 8'hCD);
    rd(2, "R4"); rd(2, "R4");

    // R7 increment and decrement address, R6 remaining count
    inc(0, 5);
    rd(0, "R7"); rd(0, "R7");
    rd(1, "R6"); rd(1, "R6");
    dir_down = 4'b0001;
    rd(0, "R7"); rd(0, "R7");
    dir_down = 4'b0000;

    // R6 count underflow wraps
    wr(5, 8'h03); wr(5, 8'h00);
    inc(2, 16'h0010);
    rd(5, "R6"); rd(5, "R6");

    // R9 step dropped on the channel being reloaded, kept on another
    wr(6, 8'h00);
    cyc(0, 1, 6, 8'h40, 0, 1, 3, 7, "");
    rd(6, "R9"); rd(6, "R9");
    cyc(0, 0, 0, 8'h00, 0, 1, 2, 1, "");
    cyc(0, 1, 4, 8'h80, 0, 1, 2, 2, "");
    cyc(0, 1, 4, 8'h00, 0, 1, 3, 3, "");
    rd(4, "R9"); rd(4, "R9");
    rd(6, "R9"); rd(6, "R9");

    // R3 clear wins over a toggle in the same cycle (pointer was 0)
    cyc(1, 0, 0, 8'h00, 1, 0, 0, 0, "R3");
    rd(0, "R3"); rd(0, "R3");

    // R1 out-of-window accesses ignored
    wr(2, 8'h55);
    wr(8, 8'hEE);
    cyc(1, 0, 9, 8'h00, 0, 0, 0, 0, "R1");
    wr(2, 8'h66);
    rd(2, "R1"); rd(2, "R1");
    rd(1, "R1"); rd(1, "R1");

    // R11 read and write together: only the write happens
    cyc(1, 1, 3, 8'h21, 0, 0, 0, 0, "R11");
    wr(3, 8'h43);
    rd(3, "R11"); rd(3, "R11");

    // word mode (SHIFT=1): R1 port bit 0 ignored, R8 shifted byte extraction
    wcyc(0, 1, 4, 8'h34, 0, 0, 8'h00, "");
    wcyc(0, 1, 5, 8'h12, 0, 0, 8'h00, "");
    wcyc(0, 1, 6, 8'h10, 0, 0, 8'h00, "");
    wcyc(0, 1, 7, 8'h00, 0, 0, 8'h00, "");
    wcyc(1, 0, 6, 8'h00, 0, 0, 8'h10, "R8");
    wcyc(1, 0, 6, 8'h00, 0, 0, 8'h00, "R8");
    wcyc(0, 0, 0, 8'h00, 1, 2, 8'h00, "");
    wcyc(1, 0, 6, 8'h00, 0, 0, 8'h0F, "R6");
    wcyc(1, 0, 7, 8'h00, 0, 0, 8'h00, "R6");
    wcyc(1, 0, 4, 8'h00, 0, 0, 8'h35, "R7");
    wcyc(1, 0, 5, 8'h00, 0, 0, 8'h12, "R1");

    repeat (3) @(negedge clk);
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      total++; bad++;
      $display("FAIL %s missing response: actual=none expected=%02h", it.tag, it.exp);
    end
    while (wq.size() > 0) begin
      item_t it;
      it = wq.pop_front();
      total++; bad++;
      $display("FAIL %s word mode missing response: actual=none expected=%02h", it.tag, it.exp);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule